// File: doc/BRIEF.md
# Stop-Grant and Auto-Halt Power Sequencer

This block is the power-state controller of a processor core. It takes a low-priority request to stop the core clock, a strobe that says a halt instruction has just executed, and a flag that marks an instruction boundary. It walks the core through a fixed shutdown sequence. First it freezes instruction fetch. Then it waits until every internal queue reports empty. Next it asks the bus unit for a stop-grant bus cycle, and only after that cycle is acknowledged does it gate the internal clock. A halt instruction takes a shorter path: it runs a halt bus cycle and parks the core in an auto-halt powerdown state.

The two low-power paths can nest. A stop-clock request that arrives while the core sits in auto-halt produces a stop-grant cycle without a new drain, because the core is already quiet. A one-bit origin register records where stop-grant was entered from. When the request is released, the core goes back to that place, either to run or to auto-halt. While in stop-grant the external clock may stop altogether, which moves the machine into stop-clock. That state is left only after the clock comes back.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the state code is 0 (RUN), core_clk_en is 1, and bus_req, drain_req and prefetch_stop are 0.
- R2: In RUN, a stop request moves the machine to DRAIN (code 1) only in a cycle where insn_boundary is 1. Without the boundary it stays in RUN.
- R3: In DRAIN, prefetch_stop and drain_req are 1. The machine moves on to SG_CYCLE (code 2) only when every bit of drain_done is 1.
- R4: In SG_CYCLE, bus_req is 1 and bus_type is 0 (stop grant). The machine stays there until bus_ready or bus_burst_ready is 1, then enters STOP_GRANT (code 3).
- R5: core_clk_en is 0 in STOP_GRANT, STOP_CLOCK (code 4) and AUTO_HALT (code 6), and 1 in every other state.
- R6: In STOP_GRANT, clk_stopped = 1 moves the machine to STOP_CLOCK, and this takes priority over a release. STOP_CLOCK is left only when clk_stopped returns to 0, and the move is to STOP_GRANT.
- R7: In RUN, halt_exec moves the machine to HALT_CYCLE (code 5), even when a stop request meets a boundary in the same cycle. In HALT_CYCLE, bus_req is 1 and bus_type is 1 (halt), and either ready input moves the machine to AUTO_HALT.
- R8: In AUTO_HALT, a stop request moves the machine straight to SG_CYCLE, with no DRAIN step.
- R9: In STOP_GRANT with stop_req at 0, the machine returns to AUTO_HALT if it reached stop-grant from AUTO_HALT, and to RUN if it came from DRAIN.
- R10: In AUTO_HALT, wake_irq returns the machine to RUN only when stop_req is 0. A pending stop request wins. wake_irq has no effect in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | Low-priority request to stop the core clock (level) |
| halt_exec | input | 1 | One-cycle strobe: a halt instruction has executed |
| insn_boundary | input | 1 | Current cycle is an instruction boundary |
| drain_done | input | NUM_DRAIN | Per-queue empty flags (prefetch, pipeline, write buffer) |
| bus_ready | input | 1 | Bus cycle acknowledge |
| bus_burst_ready | input | 1 | Burst bus cycle acknowledge |
| clk_stopped | input | 1 | External input clock is fully stopped |
| wake_irq | input | 1 | Interrupt that ends auto-halt |
| prefetch_stop | output | 1 | Freeze instruction prefetch |
| drain_req | output | 1 | Ask pipelines and write buffers to empty |
| bus_req | output | 1 | Request a special bus cycle |
| bus_type | output | 1 | Special cycle type: 0 stop grant, 1 halt |
| core_clk_en | output | 1 | Internal clock enable |
| state_code | output | 3 | Current state encoding |

## Verification
The bench builds the block with NUM_DRAIN = 3, the default, so all eight drain_done patterns can be swept in DRAIN. This shows that any single missing queue holds the sequence back. Each state is then reached along both entry paths, from RUN and from AUTO_HALT, so the origin register is exercised in both directions. The bench also drives the contested cases: halt meeting a stop request, wake meeting a stop request, clock stop meeting a release, and wake outside auto-halt. Each of these is checked against state codes and output levels that the bench derives from the requirements.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_RUN        = 3'd0,
        ST_DRAIN      = 3'd1,
        ST_SG_CYCLE   = 3'd2,
        ST_STOP_GRANT = 3'd3,
        ST_STOP_CLOCK = 3'd4,
        ST_HALT_CYCLE = 3'd5,
        ST_AUTO_HALT  = 3'd6
    } pwr_state_e;

    localparam logic BUS_TYPE_STOP_GRANT = 1'b0;
    localparam logic BUS_TYPE_HALT       = 1'b1;

    localparam logic ORIGIN_RUN  = 1'b0;
    localparam logic ORIGIN_HALT = 1'b1;

endpackage

// File: rtl/pwr_drain_join.sv
module pwr_drain_join #(
    parameter int NUM_DRAIN = 3
) (
    input  logic [NUM_DRAIN-1:0] done_in,
    output logic                 all_done
);

    logic [NUM_DRAIN:0] chain;

    assign chain[0] = 1'b1;

    for (genvar i = 0; i < NUM_DRAIN; i++) begin : g_join
        assign chain[i+1] = chain[i] & done_in[i];
    end

    assign all_done = chain[NUM_DRAIN];

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stop_req,
    input  logic               halt_exec,
    input  logic               insn_boundary,
    input  logic               drained,
    input  logic               bus_ack,
    input  logic               clk_stopped,
    input  logic               wake_irq,
    output logic               prefetch_stop,
    output logic               drain_req,
    output logic               bus_req,
    output logic               bus_type,
    output logic               core_clk_en,
    output logic [STATE_W-1:0] state_code
);

    pwr_state_e state_q, state_d;
    logic       origin_q, origin_d;

    // next-state and origin selection
    always_comb begin
        state_d  = state_q;
        origin_d = origin_q;
        unique case (state_q)
            ST_RUN: begin
                if (halt_exec) begin
                    state_d = ST_HALT_CYCLE;
                end else if (stop_req && insn_boundary) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (drained) begin
                    state_d  = ST_SG_CYCLE;
                    origin_d = ORIGIN_RUN;
                end
            end
            ST_SG_CYCLE: begin
                if (bus_ack) begin
                    state_d = ST_STOP_GRANT;
                end
            end
            ST_STOP_GRANT: begin
                if (clk_stopped) begin
                    state_d = ST_STOP_CLOCK;
                end else if (!stop_req) begin
                    state_d = (origin_q == ORIGIN_HALT) ? ST_AUTO_HALT : ST_RUN;
                end
            end
            ST_STOP_CLOCK: begin
                if (!clk_stopped) begin
                    state_d = ST_STOP_GRANT;
                end
            end
            ST_HALT_CYCLE: begin
                if (bus_ack) begin
                    state_d = ST_AUTO_HALT;
                end
            end
            ST_AUTO_HALT: begin
                if (stop_req) begin
                    state_d  = ST_SG_CYCLE;
                    origin_d = ORIGIN_HALT;
                end else if (wake_irq) begin
                    state_d = ST_RUN;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // state and origin registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            origin_q <= ORIGIN_RUN;
        end else begin
            state_q  <= state_d;
            origin_q <= origin_d;
        end
    end

    // Moore outputs
    always_comb begin
        prefetch_stop = 1'b0;
        drain_req     = 1'b0;
        bus_req       = 1'b0;
        bus_type      = BUS_TYPE_STOP_GRANT;
        core_clk_en   = 1'b1;
        unique case (state_q)
            ST_RUN: begin
            end
            ST_DRAIN: begin
                prefetch_stop = 1'b1;
                drain_req     = 1'b1;
            end
            ST_SG_CYCLE: begin
                prefetch_stop = 1'b1;
                bus_req       = 1'b1;
                bus_type      = BUS_TYPE_STOP_GRANT;
            end
            ST_STOP_GRANT, ST_STOP_CLOCK: begin
                prefetch_stop = 1'b1;
                core_clk_en   = 1'b0;
            end
            ST_HALT_CYCLE: begin
                bus_req  = 1'b1;
                bus_type = BUS_TYPE_HALT;
            end
            ST_AUTO_HALT: begin
                core_clk_en = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign state_code = state_q;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int NUM_DRAIN = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_req,
    input  logic                 halt_exec,
    input  logic                 insn_boundary,
    input  logic [NUM_DRAIN-1:0] drain_done,
    input  logic                 bus_ready,
    input  logic                 bus_burst_ready,
    input  logic                 clk_stopped,
    input  logic                 wake_irq,
    output logic                 prefetch_stop,
    output logic                 drain_req,
    output logic                 bus_req,
    output logic                 bus_type,
    output logic                 core_clk_en,
    output logic [STATE_W-1:0]   state_code
);

    logic drained;
    logic bus_ack;

    assign bus_ack = bus_ready | bus_burst_ready;

    pwr_drain_join #(
        .NUM_DRAIN (NUM_DRAIN)
    ) u_join (
        .done_in  (drain_done),
        .all_done (drained)
    );

    pwr_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .halt_exec     (halt_exec),
        .insn_boundary (insn_boundary),
        .drained       (drained),
        .bus_ack       (bus_ack),
        .clk_stopped   (clk_stopped),
        .wake_irq      (wake_irq),
        .prefetch_stop (prefetch_stop),
        .drain_req     (drain_req),
        .bus_req       (bus_req),
        .bus_type      (bus_type),
        .core_clk_en   (core_clk_en),
        .state_code    (state_code)
    );

endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
    parameter int NUM_DRAIN = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stop_req,
    input logic                 halt_exec,
    input logic                 insn_boundary,
    input logic [NUM_DRAIN-1:0] drain_done,
    input logic                 bus_ready,
    input logic                 bus_burst_ready,
    input logic                 clk_stopped,
    input logic                 wake_irq,
    input logic                 prefetch_stop,
    input logic                 drain_req,
    input logic                 bus_req,
    input logic                 bus_type,
    input logic                 core_clk_en,
    input logic [2:0]           state_code
);

    // R2: no departure from RUN without a boundary or halt
    a_r2_boundary_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0 && !halt_exec && !insn_boundary) |=> state_code == 3'd0);

    // R3: drain request never appears with prefetch still running
    a_r3_drain_after_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> prefetch_stop);

    // R3: a partial drain holds the machine in DRAIN
    a_r3_partial_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && !(&drain_done)) |=> state_code == 3'd1);

    // R4: acknowledged stop-grant cycle leads to STOP_GRANT with the clock gated
    a_r4_ack_to_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_type == 1'b0 && (bus_ready || bus_burst_ready))
        |=> (state_code == 3'd3 && !core_clk_en));

    // R6: stopped input clock in STOP_GRANT leads to STOP_CLOCK
    a_r6_clock_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && clk_stopped) |=> state_code == 3'd4);

    // R6: STOP_CLOCK held while the input clock stays stopped
    a_r6_clock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4 && clk_stopped) |=> state_code == 3'd4);

    // R8: stop-grant cycle is entered only from DRAIN or AUTO_HALT
    a_r8_sg_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd2 && $past(state_code) != 3'd2)
        |-> ($past(state_code) == 3'd1 || $past(state_code) == 3'd6));

    // R9: release from STOP_GRANT lands in RUN or AUTO_HALT with the clock enable consistent
    a_r9_release_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && !stop_req && !clk_stopped)
        |=> (state_code == 3'd0 || state_code == 3'd6));

    // R10: wake outside AUTO_HALT leaves STOP_GRANT in place while the request is held
    a_r10_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && stop_req && !clk_stopped && wake_irq) |=> state_code == 3'd3);

endmodule

bind pwr_seq_top pwr_seq_checker #(.NUM_DRAIN(NUM_DRAIN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .stop_req        (stop_req),
    .halt_exec       (halt_exec),
    .insn_boundary   (insn_boundary),
    .drain_done      (drain_done),
    .bus_ready       (bus_ready),
    .bus_burst_ready (bus_burst_ready),
    .clk_stopped     (clk_stopped),
    .wake_irq        (wake_irq),
    .prefetch_stop   (prefetch_stop),
    .drain_req       (drain_req),
    .bus_req         (bus_req),
    .bus_type        (bus_type),
    .core_clk_en     (core_clk_en),
    .state_code      (state_code)
);

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DRAIN  = 3;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 stop_req, halt_exec, insn_boundary;
    logic [NUM_DRAIN-1:0] drain_done;
    logic                 bus_ready, bus_burst_ready, clk_stopped, wake_irq;
    logic                 prefetch_stop, drain_req, bus_req, bus_type, core_clk_en;
    logic [2:0]           state_code;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_top #(.NUM_DRAIN(NUM_DRAIN)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .stop_req        (stop_req),
        .halt_exec       (halt_exec),
        .insn_boundary   (insn_boundary),
        .drain_done      (drain_done),
        .bus_ready       (bus_ready),
        .bus_burst_ready (bus_burst_ready),
        .clk_stopped     (clk_stopped),
        .wake_irq        (wake_irq),
        .prefetch_stop   (prefetch_stop),
        .drain_req       (drain_req),
        .bus_req         (bus_req),
        .bus_type        (bus_type),
        .core_clk_en     (core_clk_en),
        .state_code      (state_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R5: clock enable expected from state code
    function automatic int exp_clk_en(input int code);
        return (code == 3 || code == 4 || code == 6) ? 0 : 1;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_state(input string req, input int code);
        chk(req, int'(state_code), code);
        chk("R5 clk_en", int'(core_clk_en), exp_clk_en(code));
    endtask

    task automatic go_auto_halt();
        halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        expect_state("R7 halt cycle", 5);
        bus_ready = 1'b1;
        tick();
        bus_ready = 1'b0;
        expect_state("R7 auto halt", 6);
    endtask

    initial begin
        rst_n = 1'b0; stop_req = 1'b0; halt_exec = 1'b0; insn_boundary = 1'b0;
        drain_done = '0; bus_ready = 1'b0; bus_burst_ready = 1'b0;
        clk_stopped = 1'b0; wake_irq = 1'b0;
        tick(); tick();
        // R1 reset state
        expect_state("R1 reset", 0);
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 drain_req", int'(drain_req), 0);
        chk("R1 prefetch_stop", int'(prefetch_stop), 0);
        rst_n = 1'b1;

        // R2 no boundary: stay in RUN
        stop_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            expect_state("R2 no boundary", 0);
        end
        insn_boundary = 1'b1;
        tick();
        insn_boundary = 1'b0;
        expect_state("R2 boundary", 1);
        chk("R3 prefetch_stop", int'(prefetch_stop), 1);
        chk("R3 drain_req", int'(drain_req), 1);

        // R3 sweep every partial drain pattern
        for (int p = 0; p < (1 << NUM_DRAIN) - 1; p++) begin
            drain_done = p[NUM_DRAIN-1:0];
            tick();
            expect_state("R3 partial drain", 1);
        end
        drain_done = '1;
        tick();
        drain_done = '0;
        expect_state("R3 drained", 2);
        chk("R4 bus_req", int'(bus_req), 1);
        chk("R4 bus_type", int'(bus_type), 0);

        // R4 wait for acknowledge; wake ignored here (R10)
        wake_irq = 1'b1;
        tick(); tick();
        wake_irq = 1'b0;
        expect_state("R4 hold no ack", 2);
        bus_ready = 1'b1;
        tick();
        bus_ready = 1'b0;
        expect_state("R4 stop grant", 3);
        chk("R4 bus_req drop", int'(bus_req), 0);

        // R10 wake ignored in STOP_GRANT
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        expect_state("R10 wake ignored", 3);

        // R6 clock stop beats release
        clk_stopped = 1'b1;
        stop_req = 1'b0;
        tick();
        expect_state("R6 stop clock", 4);
        tick();
        expect_state("R6 stop clock hold", 4);
        clk_stopped = 1'b0;
        tick();
        expect_state("R6 clock resumed", 3);
        tick();
        expect_state("R9 release to run", 0);

        // R7 halt path, burst ready ack
        halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        expect_state("R7 halt cycle", 5);
        chk("R7 bus_req", int'(bus_req), 1);
        chk("R7 bus_type", int'(bus_type), 1);
        tick();
        expect_state("R7 hold no ack", 5);
        bus_burst_ready = 1'b1;
        tick();
        bus_burst_ready = 1'b0;
        expect_state("R7 auto halt", 6);
        tick();
        expect_state("R10 no wake stays", 6);

        // R8 stop from auto-halt goes straight to SG cycle
        stop_req = 1'b1;
        tick();
        expect_state("R8 sg from halt", 2);
        chk("R8 no drain", int'(drain_req), 0);
        bus_burst_ready = 1'b1;
        tick();
        bus_burst_ready = 1'b0;
        expect_state("R8 stop grant", 3);
        stop_req = 1'b0;
        tick();
        expect_state("R9 release to halt", 6);
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        expect_state("R10 wake to run", 0);

        // R10 wake with pending stop
        go_auto_halt();
        stop_req = 1'b1;
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        expect_state("R10 stop beats wake", 2);
        bus_ready = 1'b1;
        tick();
        bus_ready = 1'b0;
        // R6 clock stop path entered from halt, then release to halt
        clk_stopped = 1'b1;
        tick();
        expect_state("R6 stop clock from halt", 4);
        clk_stopped = 1'b0;
        stop_req = 1'b0;
        tick();
        expect_state("R6 resume", 3);
        tick();
        expect_state("R9 release to halt after stop clock", 6);
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        expect_state("R10 wake", 0);

        // R7 halt beats stop at a boundary
        stop_req = 1'b1;
        insn_boundary = 1'b1;
        halt_exec = 1'b1;
        tick();
        halt_exec = 1'b0;
        insn_boundary = 1'b0;
        expect_state("R7 halt priority", 5);
        bus_ready = 1'b1;
        tick();
        bus_ready = 1'b0;
        expect_state("R7 auto halt", 6);
        tick();
        expect_state("R8 pending stop from halt", 2);
        stop_req = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule